// File: doc/BRIEF.md
# Single-Slope Converter Sequencer with Result Debounce

This block is the digital side of a 6-bit single-slope analog-to-digital converter. It drives a ramp code to an external ramp DAC and advances that code on each enable tick. It samples a one-bit comparator flag, which rises once the ramp has reached the analog input. When the flag rises, the block captures the current code as the conversion result. It then holds the ramp in a conversion-reset phase for one tick before the next ramp begins.

The published result register does not take every captured code. In its default mode, a debounce stage updates the register only after four conversions in a row have produced exactly the same code. Once that has happened, each further identical conversion refreshes the register again. A bypass input makes every completed conversion update the register.

The result leaves the block as a held register plus a one-cycle `res_valid` strobe. This is a valid-only stream with no ready input and no back-pressure: the consumer must take `result` in the cycle the strobe is high. The register holds its value until the next strobe. The ramp DAC, the comparator, the reference and the input selection are outside this block.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, `result` is 00h, `res_valid` is 0, `conv_rst` is 0 and `ramp_code` is 00h. The first ramp begins immediately at code 0.
- R2: During a ramp, `ramp_code` rises by exactly one on each clock edge at which `tick` is 1. It does not change on an edge at which `tick` is 0. A conversion of input level v therefore uses min(v,63)+1 ramp ticks.
- R3: The captured code is the first ramp code at which `cmp_hi` is 1 on a tick edge (`cmp_hi` = 1 means ramp ≥ input). An input at or below code 0 yields 00h.
- R4: If `cmp_hi` never rises up to and including code 3Fh, the conversion completes at 3Fh with result 3Fh.
- R5: On the capture edge, `conv_rst` goes to 1 and `ramp_code` returns to 00h. Both hold until the next tick edge. On that edge `conv_rst` drops, and the comparator is evaluated at code 0 on the tick after that.
- R6: With `filt_off` = 1, every conversion updates `result`, and `res_valid` pulses one clock after the capture edge.
- R7: With `filt_off` = 0, `result` updates only on the conversion that makes four consecutive identical codes. The match count restarts at 1 whenever a code differs from the one before it, and the first conversion after reset counts as 1. The count follows every conversion in both modes.
- R8: With `filt_off` = 0, once four matches have been seen, each further identical conversion updates `result` again and pulses `res_valid`.
- R9: `res_valid` is a single-cycle pulse. `result` changes only in a cycle in which `res_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable that advances the sequencer by one step |
| filt_off | input | 1 | 1 = publish every conversion, 0 = four-match debounce |
| cmp_hi | input | 1 | Comparator flag, 1 when the ramp is at or above the input |
| ramp_code | output | 6 | Code driven to the ramp DAC |
| conv_rst | output | 1 | Conversion reset, high between capture and the next ramp |
| result | output | 6 | Published conversion result |
| res_valid | output | 1 | One-cycle strobe marking an update of `result` |

## Verification
The bench builds the block with its default parameters: 6-bit codes and a four-deep match requirement. These values make the full 64-step ramp and the no-trip case at 3Fh cheap to reach. Four-long runs, broken runs and runs that continue past four all fit in a short sequence. The tick is driven on every cycle and then on every third cycle, so that hold-without-tick and the reset-phase length are exercised as well.

// File: rtl/radc_pkg.sv
package radc_pkg;
  typedef enum logic {
    SEQ_RAMP = 1'b0,
    SEQ_HOLD = 1'b1
  } seq_state_e;
endpackage

// File: rtl/ramp_sequencer.sv
module ramp_sequencer #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmp_hi,
  output logic [CODE_W-1:0] ramp_code,
  output logic              conv_rst,
  output logic              smp_valid,
  output logic [CODE_W-1:0] smp_code
);
  import radc_pkg::*;

  localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

  seq_state_e state_q;
  logic       trip;

  // Conversion ends on the first tick where the ramp meets the input, or at the top code
  assign trip     = cmp_hi || (ramp_code == TOP_CODE);
  assign conv_rst = (state_q == SEQ_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SEQ_RAMP;
      ramp_code <= '0;
      smp_valid <= 1'b0;
      smp_code  <= '0;
    end else begin
      smp_valid <= 1'b0;
      if (tick) begin
        unique case (state_q)
          SEQ_RAMP: begin
            if (trip) begin
              smp_code  <= ramp_code;
              smp_valid <= 1'b1;
              ramp_code <= '0;
              state_q   <= SEQ_HOLD;
            end else begin
              ramp_code <= ramp_code + 1'b1;
            end
          end
          SEQ_HOLD: state_q <= SEQ_RAMP;
          default:  state_q <= SEQ_RAMP;
        endcase
      end
    end
  end
endmodule

// File: rtl/match_filter.sv
module match_filter #(
  parameter int CODE_W  = 6,
  parameter int MATCH_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              bypass,
  output logic [CODE_W-1:0] result,
  output logic              res_valid
);
  localparam int             CNT_W   = $clog2(MATCH_N + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MATCH_N);

  logic [CODE_W-1:0] last_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic              publish;

  // Run length of identical codes, saturating at the required depth
  always_comb begin
    if (cnt_q == '0 || smp_code != last_q) begin
      cnt_d = CNT_W'(1);
    end else if (cnt_q == CNT_TOP) begin
      cnt_d = CNT_TOP;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign publish = bypass || (cnt_d == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q    <= '0;
      cnt_q     <= '0;
      result    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (smp_valid) begin
        last_q <= smp_code;
        cnt_q  <= cnt_d;
        if (publish) begin
          result    <= smp_code;
          res_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int CODE_W  = 6,
  parameter int MATCH_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              filt_off,
  input  logic              cmp_hi,
  output logic [CODE_W-1:0] ramp_code,
  output logic              conv_rst,
  output logic [CODE_W-1:0] result,
  output logic              res_valid
);
  logic              smp_valid;
  logic [CODE_W-1:0] smp_code;

  ramp_sequencer #(.CODE_W(CODE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmp_hi    (cmp_hi),
    .ramp_code (ramp_code),
    .conv_rst  (conv_rst),
    .smp_valid (smp_valid),
    .smp_code  (smp_code)
  );

  match_filter #(.CODE_W(CODE_W), .MATCH_N(MATCH_N)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_code  (smp_code),
    .bypass    (filt_off),
    .result    (result),
    .res_valid (res_valid)
  );
endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
module ramp_adc_ctrl_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              filt_off,
  input logic              cmp_hi,
  input logic [CODE_W-1:0] ramp_code,
  input logic              conv_rst,
  input logic [CODE_W-1:0] result,
  input logic              res_valid
);
  localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

  logic capture;
  assign capture = tick && !conv_rst && (cmp_hi || ramp_code == TOP_CODE);

  AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(ramp_code) && $stable(conv_rst))); // R2

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !conv_rst && !cmp_hi && ramp_code != TOP_CODE)
      |=> (ramp_code == CODE_W'($past(ramp_code) + 1'b1))); // R2

  AST_CAPTURE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (conv_rst && ramp_code == '0)); // R5

  AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && conv_rst) |=> (!conv_rst && ramp_code == '0)); // R5

  AST_BYPASS_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ##1 (res_valid || !$past(filt_off))); // R6

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R9

  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> res_valid); // R9
endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .filt_off  (filt_off),
  .cmp_hi    (cmp_hi),
  .ramp_code (ramp_code),
  .conv_rst  (conv_rst),
  .result    (result),
  .res_valid (res_valid)
);

// File: tb/ramp_adc_ctrl_bench.sv
module ramp_adc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 6;
  localparam int MATCH_N    = 4;
  localparam int TOP        = (1 << CODE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              filt_off = 1'b0;
  logic              cmp_hi;
  logic [CODE_W-1:0] ramp_code;
  logic              conv_rst;
  logic [CODE_W-1:0] result;
  logic              res_valid;

  int vin = 0;
  int tick_div = 1;
  int checks = 0;
  int fails = 0;
  int m_cnt = 0;
  int m_last = 0;
  bit done_flag = 1'b0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Analog model: comparator trips once ramp reaches input level
  assign cmp_hi = (int'(ramp_code) >= vin);

  ramp_adc_ctrl #(.CODE_W(CODE_W), .MATCH_N(MATCH_N)) u_ramp_adc_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .filt_off  (filt_off),
    .cmp_hi    (cmp_hi),
    .ramp_code (ramp_code),
    .conv_rst  (conv_rst),
    .result    (result),
    .res_valid (res_valid)
  );

  initial begin : tick_gen
    int phase;
    phase = 0;
    forever begin
      @(negedge clk);
      phase = (phase + 1) % tick_div;
      tick = (phase == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every published result must match the next scoreboard item
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 R9 unexpected publish", int'(result), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(result) == e, "R3 R4 R6 R7 R8 published value", int'(result), e);
      end
    end
  end

  // Driver: one conversion at input level v, with the debounce model
  task automatic conv(input int v);
    int code;
    int ticks;
    vin = v;
    code = (v > TOP) ? TOP : v;
    if (m_cnt == 0 || code != m_last) m_cnt = 1;
    else if (m_cnt < MATCH_N) m_cnt++;
    m_last = code;
    if (filt_off || m_cnt == MATCH_N) exp_q.push_back(code);
    while (conv_rst) begin @(negedge clk); #1; end
    ticks = 0;
    while (!conv_rst) begin
      if (tick) ticks++;
      @(negedge clk); #1;
    end
    check(ticks == code + 1, "R2 ramp tick count", ticks, code + 1);
    check(ramp_code == '0, "R5 ramp at zero in reset phase", int'(ramp_code), 0);
  endtask

  task automatic set_mode(input bit b);
    @(negedge clk); #1;
    filt_off = b;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin : main
    vin = 5;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(result == '0 && !res_valid && !conv_rst && ramp_code == '0,
          "R1 reset state", int'(result), 0);
    rst_n = 1'b1;
    // R7: broken run publishes nothing, then four 9s publish
    conv(5); conv(5); conv(5); conv(9);
    conv(9); conv(9); conv(9);
    // R8: continued identical codes refresh
    conv(9); conv(9);
    // R7: restart on change
    conv(20); conv(20); conv(21); conv(21); conv(21); conv(21);
    // R6, R3, R4 with bypass and slower ticks
    tick_div = 3;
    set_mode(1'b1);
    conv(0); conv(64); conv(33); conv(33); conv(12);
    set_mode(1'b0);
    // R4 under debounce: no-trip code four times
    conv(70); conv(64); conv(64); conv(64);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 R7 missing publishes", exp_q.size(), 0);
    check(result == 6'(TOP), "R4 final held result", int'(result), TOP);
    finish_run();
  end
endmodule